// File: doc/BRIEF.md
# Edge Port Interrupt Detector

This block watches a small bank of external interrupt pins and turns their activity into interrupt requests, one per pin, for a downstream interrupt controller. Software picks a sense mode for each pin: level-sensitive (active low), rising edge, falling edge or either edge. It also sets each pin's direction and whether the pin may raise a request. Pin 0 is a reserved slot. Only pins 1 and up can act as interrupt lines.

Each pin input first passes through a synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier. In an edge mode, a detected edge sets a sticky flag, and the request follows that flag until software clears it by writing a 1 to the flag bit. In level mode no flag is kept, and the request follows the synchronized pin directly. The register port is a plain single-cycle write strobe with a combinational read. It is a control path, so it has no valid/ready handshake and never applies back-pressure.

Register map (address on `reg_addr`):
- 0: sense modes, 2 bits per pin, with pin n at bits [2n+1:2n].
- 1: direction, 1 bit per pin.
- 2: request enable, 1 bit per pin.
- 3: event flags, read; write 1 to clear.

Top module: `edge_irq_port`

## Requirements
- R1: Pin 0 never sets its flag and never asserts `irq_req[0]`, whatever its mode, enable or input activity.
- R2: The sense register at address 0 stores pin n's mode in bits [2n+1:2n], and it reads back as written. The direction register (address 1) and the enable register (address 2) also read back as written, and the direction bits also drive `pin_dir`. Mode code 00 is level, 01 is rising edge, 10 is falling edge and 11 is both edges.
- R3: In level mode, an enabled input pin asserts its request while its synchronized input is low. The request appears on the second rising clock edge after the pin changes. No flag is latched in level mode.
- R4: In rising-edge mode, a low-to-high transition sets the pin's flag. A high-to-low transition does not set it. The request follows the flag.
- R5: In falling-edge mode, a high-to-low transition sets the flag. A low-to-high transition does not set it.
- R6: In both-edges mode, either transition sets the flag.
- R7: A pin whose direction bit is 1 (output) neither sets its flag nor raises a request.
- R8: With its enable bit at 0, a pin raises no request. Its flag still records edges, and the request appears as soon as the enable is set.
- R9: Writing 1 to a bit of the flag register (address 3) clears that flag. Writing 0 leaves it unchanged. An uncleared flag stays set.
- R10: When a new edge and a clear for the same flag fall in the same clock cycle, the flag stays set.
- R11: After reset, every register reads 0 and no request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pin_in | input | 8 | External pin levels, idle high |
| pin_dir | output | 8 | Direction bits, 1 = output |
| irq_req | output | 8 | Per-pin interrupt request |

## Verification
The bench builds the block with its default parameters: eight pins, which gives a full 16-bit sense register and a two-stage synchronizer. With eight pins, every position of the 2-bit mode field is reachable, up to the top pin at bits [15:14], as is the reserved pin 0 slot. Because the synchronizer depth is fixed at two, the bench can place a clear write in exactly the cycle where a new edge reaches the flag. That makes the edge-versus-clear collision observable at the ports.

// File: rtl/edge_port_pkg.sv
package edge_port_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_SENSE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 2'd3;

endpackage

// File: rtl/edge_port_sync.sv
module edge_port_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  // Reset to the idle-high level so no edge is seen when reset is released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '1;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '1;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/edge_port_regs.sv
module edge_port_regs
  import edge_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned DATA_W  = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] flags,
  output logic [DATA_W-1:0]   sense_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] en_q,
  output logic [NUM_PINS-1:0] clr_pulse
);

  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      dir_q   <= '0;
      en_q    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_SENSE: sense_q <= reg_wdata;
        ADDR_DIR:   dir_q   <= reg_wdata[NUM_PINS-1:0];
        ADDR_EN:    en_q    <= reg_wdata[NUM_PINS-1:0];
        default:    ;
      endcase
    end
  end

  // Write-one-to-clear strobes toward the per-pin flags.
  always_comb begin
    clr_pulse = '0;
    if (reg_wr && reg_addr == ADDR_FLAG) clr_pulse = reg_wdata[NUM_PINS-1:0];
  end

  always_comb begin
    case (reg_addr)
      ADDR_SENSE: reg_rdata = sense_q;
      ADDR_DIR:   reg_rdata = {{PAD_W{1'b0}}, dir_q};
      ADDR_EN:    reg_rdata = {{PAD_W{1'b0}}, en_q};
      default:    reg_rdata = {{PAD_W{1'b0}}, flags};
    endcase
  end

endmodule

// File: rtl/edge_port_pin.sv
module edge_port_pin
  import edge_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic [1:0] mode,
  input  logic       is_output,
  input  logic       enable,
  input  logic       clr,
  output logic       flag,
  output logic       req
);

  sense_e mode_e;
  logic   prev_q;
  logic   rise, fall, evt;

  assign mode_e = sense_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;

  always_comb begin
    case (mode_e)
      SENSE_RISE: evt = rise;
      SENSE_FALL: evt = fall;
      SENSE_BOTH: evt = rise | fall;
      default:    evt = 1'b0;
    endcase
    if (is_output) evt = 1'b0;
  end

  // A new event has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (evt)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  always_comb begin
    if (!enable || is_output)      req = 1'b0;
    else if (mode_e == SENSE_LEVEL) req = ~pin_s;
    else                           req = flag;
  end

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !$past(flag)) |-> ($past(mode) != SENSE_LEVEL)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) && !$past(clr)) |-> flag); // R9
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt) |-> flag); // R10

endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port
  import edge_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W     = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_dir,
  output logic [NUM_PINS-1:0] irq_req
);

  logic [NUM_PINS-1:0] pin_s;
  logic [DATA_W-1:0]   sense_q;
  logic [NUM_PINS-1:0] dir_q, en_q, clr_pulse, flags;

  edge_port_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_s)
  );

  edge_port_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .flags     (flags),
    .sense_q   (sense_q),
    .dir_q     (dir_q),
    .en_q      (en_q),
    .clr_pulse (clr_pulse)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    if (n == 0) begin : g_reserved
      assign flags[n]   = 1'b0;
      assign irq_req[n] = 1'b0;
    end else begin : g_line
      edge_port_pin u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_s     (pin_s[n]),
        .mode      (sense_q[2*n+1 -: 2]),
        .is_output (dir_q[n]),
        .enable    (en_q[n]),
        .clr       (clr_pulse[n]),
        .flag      (flags[n]),
        .req       (irq_req[n])
      );
    end
  end

  assign pin_dir = dir_q;

  AST_OUTPUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_dir & irq_req) == '0); // R7
  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (~en_q & irq_req) == '0); // R8

endmodule

// File: tb/test_edge_irq_port.sv
module test_edge_irq_port;
  import edge_port_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic [7:0]  pin_dir;
  logic [7:0]  irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  edge_irq_port i_edge_irq_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_dir(pin_dir), .irq_req(irq_req)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    pin_in[n] = v;
    settle();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d, 16'h0, "R11 register after reset");
    end
    chk({8'h0, irq_req}, 16'h0, "R11 requests after reset");
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(ADDR_SENSE, 16'hA5C3); rd(ADDR_SENSE, d); chk(d, 16'hA5C3, "R2 sense readback");
    wr(ADDR_DIR, 16'h005A);   rd(ADDR_DIR, d);   chk(d, 16'h005A, "R2 dir readback");
    chk({8'h0, pin_dir}, 16'h005A, "R2 pin_dir");
    wr(ADDR_EN, 16'h0033);    rd(ADDR_EN, d);    chk(d, 16'h0033, "R2 enable readback");
    wr(ADDR_SENSE, 16'h0); wr(ADDR_DIR, 16'h0); wr(ADDR_EN, 16'h0);
  endtask

  task automatic t_level();
    logic [15:0] d;
    wr(ADDR_EN, 16'h00FE);
    @(negedge clk); pin_in[3] = 1'b0;
    @(negedge clk);
    chk({8'h0, irq_req}, 16'h0, "R3 not yet after one edge");
    @(negedge clk);
    chk({8'h0, irq_req}, 16'h0008, "R3 level request after two edges");
    rd(ADDR_FLAG, d); chk(d, 16'h0, "R3 no flag in level mode");
    wr(ADDR_FLAG, 16'h0008);
    chk({8'h0, irq_req}, 16'h0008, "R3 clear harmless in level mode");
    set_pin(3, 1'b1);
    chk({8'h0, irq_req}, 16'h0, "R3 released");
  endtask

  task automatic t_rise();
    logic [15:0] d;
    wr(ADDR_SENSE, 16'h0010);
    set_pin(2, 1'b0);
    rd(ADDR_FLAG, d); chk(d, 16'h0, "R4 falling edge ignored");
    set_pin(2, 1'b1);
    rd(ADDR_FLAG, d); chk(d, 16'h0004, "R4 rising edge flag");
    chk({8'h0, irq_req}, 16'h0004, "R4 request follows flag");
    wr(ADDR_FLAG, 16'h00FB);
    rd(ADDR_FLAG, d); chk(d, 16'h0004, "R9 write 0 keeps flag");
    wr(ADDR_FLAG, 16'h0004);
    rd(ADDR_FLAG, d); chk(d, 16'h0, "R9 write 1 clears flag");
    chk({8'h0, irq_req}, 16'h0, "R9 request drops");
  endtask

  task automatic t_fall();
    logic [15:0] d;
    wr(ADDR_SENSE, 16'h0800);
    set_pin(5, 1'b0);
    rd(ADDR_FLAG, d); chk(d, 16'h0020, "R5 falling edge flag");
    wr(ADDR_FLAG, 16'h0020);
    set_pin(5, 1'b1);
    rd(ADDR_FLAG, d); chk(d, 16'h0, "R5 rising edge ignored");
  endtask

  task automatic t_both();
    logic [15:0] d;
    wr(ADDR_SENSE, 16'hC000);
    set_pin(7, 1'b0);
    rd(ADDR_FLAG, d); chk(d, 16'h0080, "R6 falling sets");
    wr(ADDR_FLAG, 16'h0080);
    set_pin(7, 1'b1);
    rd(ADDR_FLAG, d); chk(d, 16'h0080, "R6 rising sets");
    chk({8'h0, irq_req}, 16'h0080, "R6 request");
    wr(ADDR_FLAG, 16'h0080);
  endtask

  task automatic t_dir();
    logic [15:0] d;
    wr(ADDR_SENSE, 16'h0300);
    wr(ADDR_DIR, 16'h0010);
    set_pin(4, 1'b0);
    set_pin(4, 1'b1);
    rd(ADDR_FLAG, d); chk(d, 16'h0, "R7 output pin no flag");
    chk({8'h0, irq_req}, 16'h0, "R7 output pin no request");
    wr(ADDR_DIR, 16'h0);
  endtask

  task automatic t_en();
    logic [15:0] d;
    wr(ADDR_SENSE, 16'h0004);
    wr(ADDR_EN, 16'h0);
    set_pin(1, 1'b0);
    set_pin(1, 1'b1);
    rd(ADDR_FLAG, d); chk(d, 16'h0002, "R8 flag latches while disabled");
    chk({8'h0, irq_req}, 16'h0, "R8 no request while disabled");
    wr(ADDR_EN, 16'h0002);
    chk({8'h0, irq_req}, 16'h0002, "R8 request after enable");
    wr(ADDR_FLAG, 16'h0002);
  endtask

  task automatic t_pin0();
    logic [15:0] d;
    wr(ADDR_EN, 16'h00FF);
    wr(ADDR_SENSE, 16'h0000);
    set_pin(0, 1'b0);
    chk({8'h0, irq_req}, 16'h0, "R1 pin0 level low no request");
    wr(ADDR_SENSE, 16'h0003);
    set_pin(0, 1'b1);
    set_pin(0, 1'b0);
    rd(ADDR_FLAG, d); chk(d, 16'h0, "R1 pin0 no flag");
    chk({8'h0, irq_req}, 16'h0, "R1 pin0 no request");
    set_pin(0, 1'b1);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    wr(ADDR_SENSE, 16'h0010);
    set_pin(2, 1'b0);
    @(negedge clk); pin_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_FLAG; reg_wdata = 16'h0004;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(ADDR_FLAG, d); chk(d, 16'h0004, "R10 edge wins over clear");
    wr(ADDR_FLAG, 16'h0004);
    rd(ADDR_FLAG, d); chk(d, 16'h0, "R10 later clear works");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_dir();
    t_en();
    t_pin0();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule